// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block paces one successive-approximation conversion. After a start pulse it holds the sample switch closed for a programmable number of clock cycles. It then steps through the result bits one per cycle, most significant bit first, and closes each conversion with one settling cycle. The length of the sampling window comes from a compact 4-bit code. Short windows of 1 to 3 cycles are encoded linearly. Longer windows are powers of two up to 256 cycles.

Two sampling-window codes are held side by side, one for single-channel requests and one for scan-sequence requests. A select input picks which code a conversion uses. The resolution can be 12, 8 or 6 bits. A shorter resolution stops the bit walk early and leaves the unresolved low bits at zero. When oversampling is enabled, the whole sample-and-resolve pass repeats a power-of-two number of times before one output is declared. Summing or averaging the passes is left to a downstream block.

The comparator and the capacitor DAC lie outside this block. The comparator appears only as a single decision input, read during each bit trial.

Top module: `sar_conv_seq`

## Requirements
- R1: While `rst` is high and after its release, `sh_en`, `trial` and `done` are 0 and `result` is 0, and the block is idle.
- R2: After an accepted start, `sh_en` is high for exactly L consecutive cycles, beginning with the cycle after the start. L is 1, 2 or 3 for codes 0, 1 and 2. L is 4, 8, 16, 32, 64, 128 or 256 for codes 3 through 9. L is 256 for codes 10 to 15.
- R3: When `src_scan` is 1 in the start cycle, L comes from `acq_code_scan`; otherwise it comes from `acq_code_single`. All configuration inputs are captured in the start cycle. Later changes to them have no effect on the conversion in progress.
- R4: Right after the sampling cycles come N trial cycles. In each of them exactly one bit of `trial` is high, stepping down from bit 11. N is 12 for `res_sel`=0 or 3, 8 for `res_sel`=1 and 6 for `res_sel`=2.
- R5: The value of `cmp_in` in the cycle where `trial[k]` is high becomes bit k of the result. Bits below the last resolved bit read as 0.
- R6: One extra cycle follows the last trial. In it `sh_en` and `trial` are 0. On the final pass, `done` is high for exactly that one cycle, and `result` shows the new value in that same cycle.
- R7: When `osr_en`=1, the sample-and-resolve pass runs 2^(`osr_code`+1) times, and only the last pass raises `done`. `done` falls in cycle (L+N+1) x passes, counting the cycle after the start as cycle 1. With `osr_en`=0 there is one pass, whatever `osr_code` holds.
- R8: A start pulse while a conversion is busy is ignored. Busy includes the final `done` cycle. The timing, the result and the idle state that follows are unchanged.
- R9: `result` changes only in a cycle where `done` is high. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle conversion request |
| src_scan | input | 1 | 1 selects the scan sampling code, 0 the single-channel code |
| acq_code_single | input | 4 | Sampling-window code for single-channel conversions |
| acq_code_scan | input | 4 | Sampling-window code for scan conversions |
| res_sel | input | 2 | Resolution: 0/3 = 12 bits, 1 = 8 bits, 2 = 6 bits |
| osr_en | input | 1 | Enables repeated passes per output |
| osr_code | input | 3 | Pass count is 2^(osr_code+1) when enabled |
| cmp_in | input | 1 | Comparator decision for the bit under trial |
| sh_en | output | 1 | Sample-and-hold switch enable |
| trial | output | 12 | One-hot strobe of the bit under trial |
| result | output | 12 | Last completed conversion, MSB aligned |
| done | output | 1 | One-cycle end-of-output pulse |

## Verification
The hardest case to reach from the ports is a start pulse that lands in the very cycle `done` is high. At that moment the block is still busy, but it is one edge away from idle. The bench reaches it by waiting for the rising edge of `done` and raising `start` at once for a single cycle. It then checks that no sampling window opens and that `result` stays put. Multi-pass oversampling runs are also checked cycle by cycle against the pass period, so that a missing or extra settling cycle per pass shows up as a phase error in `sh_en`.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACQ  = 2'd1,
    PH_BIT  = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_acq_decode.sv
module sar_acq_decode #(
  parameter int CODE_W  = 4,
  parameter int MAX_LOG = 8,
  parameter int LEN_W   = MAX_LOG + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [LEN_W-1:0]  len
);
  // codes 0..2 linear, 3..MAX_LOG+1 powers of two from 4, rest clamp
  always_comb begin
    if (code < CODE_W'(3))
      len = LEN_W'(code) + LEN_W'(1);
    else if (code <= CODE_W'(MAX_LOG + 1))
      len = LEN_W'(1) << (code - CODE_W'(1));
    else
      len = LEN_W'(1) << MAX_LOG;
  end

  always_comb begin
    a_r2_len_nonzero: assert (len != '0);
  end
endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS  = 12,
  parameter int LEN_W     = 9,
  parameter int PASS_W    = 9,
  parameter int BIT_IDX_W = $clog2(MAX_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [LEN_W-1:0]     len_in,
  input  logic [BIT_IDX_W-1:0] last_idx_in,
  input  logic [PASS_W-1:0]    passes_in,
  output phase_t               phase,
  output logic [BIT_IDX_W-1:0] bit_idx,
  output logic                 bit_last,
  output logic                 pass_last
);
  logic [LEN_W-1:0]     acq_cnt;
  logic [LEN_W-1:0]     len_q;
  logic [BIT_IDX_W-1:0] last_idx_q;
  logic [PASS_W-1:0]    pass_cnt;
  logic [PASS_W-1:0]    pass_max_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      acq_cnt    <= '0;
      len_q      <= '0;
      last_idx_q <= '0;
      bit_idx    <= '0;
      pass_cnt   <= '0;
      pass_max_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase      <= PH_ACQ;
          acq_cnt    <= len_in - LEN_W'(1);
          len_q      <= len_in;
          last_idx_q <= last_idx_in;
          pass_max_q <= passes_in - PASS_W'(1);
          pass_cnt   <= '0;
        end
        PH_ACQ: begin
          if (acq_cnt == '0) begin
            phase   <= PH_BIT;
            bit_idx <= BIT_IDX_W'(MAX_BITS - 1);
          end else begin
            acq_cnt <= acq_cnt - LEN_W'(1);
          end
        end
        PH_BIT: begin
          if (bit_idx == last_idx_q) phase <= PH_TAIL;
          else bit_idx <= bit_idx - BIT_IDX_W'(1);
        end
        PH_TAIL: begin
          if (pass_cnt == pass_max_q) begin
            phase <= PH_IDLE;
          end else begin
            pass_cnt <= pass_cnt + PASS_W'(1);
            phase    <= PH_ACQ;
            acq_cnt  <= len_q - LEN_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign bit_last  = (phase == PH_BIT) && (bit_idx == last_idx_q);
  assign pass_last = (pass_cnt == pass_max_q);

  // R8: once sampling or trials run, the block cannot drop to idle directly
  a_r8_busy_stays: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_ACQ || phase == PH_BIT) |=> (phase != PH_IDLE));
  // R4: trials open at the MSB
  a_r4_msb_first: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BIT && $past(phase) == PH_ACQ) |-> (bit_idx == BIT_IDX_W'(MAX_BITS - 1)));
  // R4: trials step down by one bit per cycle
  a_r4_descend: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_BIT && $past(phase) == PH_BIT) |-> (bit_idx == $past(bit_idx) - BIT_IDX_W'(1)));
  // R6: exactly one settling cycle per pass
  a_r6_single_tail: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_TAIL) |=> (phase != PH_TAIL));
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS  = 12,
  parameter int BIT_IDX_W = $clog2(MAX_BITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  phase_t               phase,
  input  logic [BIT_IDX_W-1:0] bit_idx,
  input  logic                 bit_last,
  input  logic                 pass_last,
  input  logic                 cmp_in,
  output logic [MAX_BITS-1:0]  trial,
  output logic [MAX_BITS-1:0]  result,
  output logic                 done
);
  logic [MAX_BITS-1:0] work;
  logic [MAX_BITS-1:0] work_nxt;

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_bit
    assign trial[g]    = (phase == PH_BIT) && (bit_idx == BIT_IDX_W'(g));
    assign work_nxt[g] = trial[g] ? cmp_in : work[g];

    always_ff @(posedge clk) begin
      if (rst)                  work[g] <= 1'b0;
      else if (phase == PH_ACQ) work[g] <= 1'b0;
      else                      work[g] <= work_nxt[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= bit_last && pass_last;
      if (bit_last && pass_last) result <= work_nxt;
    end
  end

  // R4: at most one bit under trial
  a_r4_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(trial));
  // R9: result moves only together with done
  a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> done);
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int MAX_BITS = 12,
  parameter int RES_MID  = 8,
  parameter int RES_LOW  = 6,
  parameter int CODE_W   = 4,
  parameter int MAX_LOG  = 8,
  parameter int OSR_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                src_scan,
  input  logic [CODE_W-1:0]   acq_code_single,
  input  logic [CODE_W-1:0]   acq_code_scan,
  input  logic [1:0]          res_sel,
  input  logic                osr_en,
  input  logic [OSR_W-1:0]    osr_code,
  input  logic                cmp_in,
  output logic                sh_en,
  output logic [MAX_BITS-1:0] trial,
  output logic [MAX_BITS-1:0] result,
  output logic                done
);
  localparam int LEN_W     = MAX_LOG + 1;
  localparam int PASS_W    = (1 << OSR_W) + 1;
  localparam int BIT_IDX_W = $clog2(MAX_BITS);

  logic [CODE_W-1:0]    code_sel;
  logic [LEN_W-1:0]     acq_len;
  logic [BIT_IDX_W-1:0] last_idx;
  logic [PASS_W-1:0]    passes;
  phase_t               phase;
  logic [BIT_IDX_W-1:0] bit_idx;
  logic                 bit_last;
  logic                 pass_last;

  assign code_sel = src_scan ? acq_code_scan : acq_code_single;

  always_comb begin
    case (res_sel)
      2'd1:    last_idx = BIT_IDX_W'(MAX_BITS - RES_MID);
      2'd2:    last_idx = BIT_IDX_W'(MAX_BITS - RES_LOW);
      default: last_idx = '0;
    endcase
  end

  assign passes = osr_en ? (PASS_W'(2) << osr_code) : PASS_W'(1);

  sar_acq_decode #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG), .LEN_W(LEN_W)) u_dec (
    .code (code_sel),
    .len  (acq_len)
  );

  sar_phase_ctrl #(
    .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .PASS_W(PASS_W), .BIT_IDX_W(BIT_IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .len_in     (acq_len),
    .last_idx_in(last_idx),
    .passes_in  (passes),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .bit_last   (bit_last),
    .pass_last  (pass_last)
  );

  sar_bit_reg #(.MAX_BITS(MAX_BITS), .BIT_IDX_W(BIT_IDX_W)) u_bits (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .bit_last (bit_last),
    .pass_last(pass_last),
    .cmp_in   (cmp_in),
    .trial    (trial),
    .result   (result),
    .done     (done)
  );

  assign sh_en = (phase == PH_ACQ);

  // R2: sampling and bit trials never overlap
  a_r2_sh_excl: assert property (@(posedge clk) disable iff (rst)
    sh_en |-> (trial == '0));
  // R6: done only in the settling cycle
  a_r6_done_tail: assert property (@(posedge clk) disable iff (rst)
    done |-> (phase == PH_TAIL && trial == '0 && !sh_en));
endmodule

// File: tb/test_sar_conv_seq.sv
`timescale 1ns/1ps
module test_sar_conv_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        src_scan = 1'b0;
  logic [3:0]  acq_code_single = '0;
  logic [3:0]  acq_code_scan = '0;
  logic [1:0]  res_sel = '0;
  logic        osr_en = 1'b0;
  logic [2:0]  osr_code = '0;
  logic        cmp_in;
  logic        sh_en;
  logic [11:0] trial;
  logic [11:0] result;
  logic        done;

  always #2.5 clk = ~clk;

  sar_conv_seq i_sar_conv_seq (
    .clk(clk), .rst(rst), .start(start), .src_scan(src_scan),
    .acq_code_single(acq_code_single), .acq_code_scan(acq_code_scan),
    .res_sel(res_sel), .osr_en(osr_en), .osr_code(osr_code), .cmp_in(cmp_in),
    .sh_en(sh_en), .trial(trial), .result(result), .done(done)
  );

  typedef struct {
    int          len;
    int          nb;
    int          ratio;
    logic [11:0] res;
  } exp_t;

  exp_t        q[$];
  exp_t        cur;
  logic [11:0] target = '0;
  logic [11:0] last_res = '0;
  bit          active = 1'b0;
  int          cyc = 0;
  int          errors = 0;
  int          checks = 0;

  // comparator model: decision equals the target bit under trial
  assign cmp_in = |(trial & target);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 3;  3: return 4;
      4: return 8;  5: return 16; 6: return 32; 7: return 64;
      8: return 128;
      default: return 256;
    endcase
  endfunction

  function automatic int nb_of(input int rs);
    if (rs == 1) return 8;
    if (rs == 2) return 6;
    return 12;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    bit ending;
    ending = 1'b0;
    if (rst) begin
      chk(sh_en == 1'b0, "R1 sh_en in reset", int'(sh_en), 0);
      chk(trial == '0, "R1 trial in reset", int'(trial), 0);
      chk(done == 1'b0, "R1 done in reset", int'(done), 0);
      chk(result == '0, "R1 result in reset", int'(result), 0);
    end else begin
      if (active) begin
        int per, w, exp_tr;
        bit exp_sh, exp_dn;
        cyc++;
        per = cur.len + cur.nb + 1;
        w = (cyc - 1) % per;
        exp_sh = (w < cur.len);
        exp_tr = (w >= cur.len && w < cur.len + cur.nb) ? (1 << (11 - (w - cur.len))) : 0;
        exp_dn = (cyc == per * cur.ratio);
        chk(sh_en == exp_sh, "R2 sh_en window", int'(sh_en), int'(exp_sh));
        chk(int'(trial) == exp_tr, "R4 trial strobe", int'(trial), exp_tr);
        chk(done == exp_dn, "R6/R7 done timing", int'(done), int'(exp_dn));
        if (exp_dn) begin
          chk(result == cur.res, "R5 result value", int'(result), int'(cur.res));
          ending = 1'b1;
        end else begin
          chk(result == last_res, "R9 result hold", int'(result), int'(last_res));
        end
        last_res = result;
      end else begin
        chk(sh_en == 1'b0 && trial == '0, "R8 idle outputs", int'({sh_en, trial}), 0);
        chk(done == 1'b0, "R8 idle done", int'(done), 0);
        chk(result == last_res, "R9 idle result hold", int'(result), int'(last_res));
      end
      if (start && !active) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected start", 1, 0);
        end else begin
          cur = q.pop_front();
          active = 1'b1;
          cyc = 0;
        end
      end
      if (ending) active = 1'b0;
    end
  end

  // driver: push the expected item, then issue the start pulse
  task automatic conv(input int cs, input int cn, input bit scan, input int rs,
                      input bit oe, input int oc, input logic [11:0] tgt,
                      input bit flip, input bit stray, input bit at_done);
    exp_t e;
    int nb;
    nb = nb_of(rs);
    e.len   = len_of(scan ? cn : cs);
    e.nb    = nb;
    e.ratio = oe ? (2 << oc) : 1;
    e.res   = tgt & (12'hFFF << (12 - nb));
    q.push_back(e);
    acq_code_single = 4'(cs);
    acq_code_scan   = 4'(cn);
    src_scan = scan;
    res_sel  = 2'(rs);
    osr_en   = oe;
    osr_code = 3'(oc);
    target   = tgt;
    start    = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (flip) begin  // R3: later config changes must not matter
      acq_code_single = 4'd9;
      acq_code_scan   = 4'd9;
      src_scan = ~scan;
      res_sel  = 2'd2;
      osr_en   = ~oe;
    end
    if (stray) begin // R8: start during sampling/trials
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    if (at_done) begin // R8: start in the done cycle
      @(posedge done); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait (!active && q.size() == 0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    conv(0, 0, 0, 0, 0, 0, 12'hA5C, 0, 0, 0);  // R2 R4 R5 code 0, 12 bits
    conv(1, 0, 0, 0, 0, 0, 12'hFFF, 0, 0, 0);  // R2 code 1
    conv(2, 0, 0, 1, 0, 0, 12'h3C7, 0, 0, 0);  // R4 8-bit early end
    conv(3, 0, 0, 2, 0, 0, 12'hFFF, 0, 0, 0);  // R4 R5 6-bit, low bits zero
    conv(5, 0, 0, 3, 0, 0, 12'h001, 0, 0, 0);  // R2 16 cycles, res_sel 3
    conv(9, 0, 0, 0, 0, 0, 12'h800, 0, 0, 0);  // R2 256 cycles
    conv(12, 0, 0, 0, 0, 0, 12'h7FE, 0, 0, 0); // R2 clamp
    conv(0, 4, 1, 0, 0, 0, 12'h136, 0, 0, 0);  // R3 scan code used
    conv(4, 0, 0, 0, 0, 0, 12'h9C3, 1, 0, 0);  // R3 config captured at start
    conv(2, 0, 0, 1, 0, 0, 12'h5A5, 0, 1, 0);  // R8 stray start while busy
    conv(1, 0, 0, 2, 1, 0, 12'h555, 0, 0, 0);  // R7 two passes
    conv(4, 0, 0, 1, 1, 2, 12'hAAA, 0, 0, 1);  // R7 eight passes, R8 start at done
    conv(0, 0, 0, 0, 0, 5, 12'h0F0, 0, 0, 0);  // R7 osr disabled, one pass
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule